// File: doc/BRIEF.md
# Audio Event Interrupt and Frame-Match Controller

This block holds the interrupt control of an audio serial-bus controller. Eight event sources share one 32-bit control word. Each source has an enable bit and a sticky pending bit. Seven sources arrive as one-cycle pulses from elsewhere in the controller. The eighth source comes from inside the block: a frame counter advances on every frame strobe, and a comparator raises the event when the count steps onto a programmed match value.

Software programs the block through a simple register bus at byte offsets. Writing the control word loads the enables and clears pending bits by writing ones. The frame count and the match value are read at their own offsets. The single interrupt output is high while any enabled source is pending. Reads are combinational on the current address.

Top module: `audio_irq_ctrl`

## Requirements
- R1: After reset, the control word (offset 0x00), the frame count (0x40) and the match value (0x50) read zero, and irqOut is low.
- R2: Source s (0 to 7) has its enable at control-word bit 17+2s and its pending flag at bit 16+2s. Source 7 is the frame-match event. Sources 6 down to 0 (message, new peak, clocks stopped, sync error, sync ok, new sample rate, status) are driven by eventPulse[6] down to eventPulse[0]. Bits 15 to 0 read zero.
- R3: A pulse sets its pending flag whatever the enable holds. The flag stays set until software clears it.
- R4: A write to offset 0x00 clears each pending flag whose even bit (16+2s) carries a 1. A 0 in that position leaves the flag alone. When an event and a clear hit the same flag in the same cycle, the flag stays set.
- R5: A write to offset 0x00 loads every enable directly from the odd bits 31, 29, ..., 17.
- R6: irqOut is high exactly when at least one source has both its enable and its pending flag set.
- R7: The frame count, read at 0x40 zero-extended, increments by one on each frameStrobe and wraps to zero after 2^CNT_W-1. Writes to 0x40 have no effect.
- R8: A write to 0x50 loads the low CNT_W bits into the match value, which reads back at 0x50.
- R9: The frame-match pending flag is set only in the cycle in which a frameStrobe advances the count onto the match value. Writing a match value equal to the current count raises nothing.
- R10: Offsets other than 0x00, 0x40 and 0x50 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Write strobe for regWrData at regAddr |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| frameStrobe | input | 1 | One-cycle pulse per audio frame |
| eventPulse | input | 7 | One-cycle pulses for sources 6..0 |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest condition to reach is the frame-match event. The count has to step onto the match value through a strobe, and a write that merely makes the two equal must raise nothing. The count also has to wrap past its top value. The bench reduces CNT_W to 10 so that a directed run of strobes crosses the wrap. Random phases keep writing match values near the current count, so that steps onto the match happen often. They are mixed with writes of equal values and with clears that collide with events.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int NUM_SRC = 8;
  localparam int FRAME_SRC = NUM_SRC - 1;
  localparam int FIELD_LSB = 16;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_COUNT = 8'h40;
  localparam logic [7:0] OFS_MATCH = 8'h50;

  typedef struct packed {
    logic               wrCtrl;
    logic               wrMatch;
    logic [NUM_SRC-1:0] enNew;
    logic [NUM_SRC-1:0] clrMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/audio_irq_regif.sv
module audio_irq_regif
  import audio_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  input  logic [NUM_SRC-1:0] enState,
  input  logic [NUM_SRC-1:0] pendState,
  input  logic [CNT_W-1:0]   cntState,
  input  logic [CNT_W-1:0]   matchState,
  output ctrlStrobe_t        strb,
  output logic [31:0]        regRdData
);
  logic hitCtrl, hitCount, hitMatch;
  logic [31:0] ctrlWord;

  assign hitCtrl  = (regAddr == ADDR_W'(OFS_CTRL));
  assign hitCount = (regAddr == ADDR_W'(OFS_COUNT));
  assign hitMatch = (regAddr == ADDR_W'(OFS_MATCH));

  always_comb begin
    ctrlWord = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      ctrlWord[FIELD_LSB + 2*s + 1] = enState[s];
      ctrlWord[FIELD_LSB + 2*s]     = pendState[s];
    end
  end

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_split
      assign strb.enNew[s]   = regWrData[FIELD_LSB + 2*s + 1];
      assign strb.clrMask[s] = regWrData[FIELD_LSB + 2*s];
    end
  endgenerate

  assign strb.wrCtrl  = regWrEn && hitCtrl;
  assign strb.wrMatch = regWrEn && hitMatch;

  always_comb begin
    regRdData = '0;
    if (hitCtrl)       regRdData = ctrlWord;
    else if (hitCount) regRdData = 32'(cntState);
    else if (hitMatch) regRdData = 32'(matchState);
  end
endmodule

// File: rtl/audio_irq_core.sv
module audio_irq_core
  import audio_irq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [CNT_W-1:0]   matchWrData,
  input  logic               frameStrobe,
  input  logic [NUM_SRC-2:0] eventPulse,
  output logic [NUM_SRC-1:0] enState,
  output logic [NUM_SRC-1:0] pendState,
  output logic [CNT_W-1:0]   cntState,
  output logic [CNT_W-1:0]   matchState,
  output logic               irqOut
);
  logic [CNT_W-1:0]   cntNext;
  logic               frameHit;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;

  assign cntNext  = CNT_W'(cntState + 1'b1);
  assign frameHit = frameStrobe && (cntNext == matchState);
  assign setVec   = {frameHit, eventPulse};
  assign clrVec   = strb.wrCtrl ? strb.clrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enState    <= '0;
      pendState  <= '0;
      cntState   <= '0;
      matchState <= '0;
    end else begin
      if (strb.wrCtrl)  enState <= strb.enNew;
      pendState <= (pendState & ~clrVec) | setVec;
      if (frameStrobe)  cntState <= cntNext;
      if (strb.wrMatch) matchState <= matchWrData;
    end
  end

  assign irqOut = |(enState & pendState);

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCtrl |=> ((pendState & $past(pendState)) == $past(pendState))); // R3
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (eventPulse != '0) |=> ((pendState[NUM_SRC-2:0] & $past(eventPulse)) == $past(eventPulse))); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> (cntState == CNT_W'($past(cntState) + 1'b1))); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> $stable(cntState)); // R7
  AST_FRAME_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && (CNT_W'(cntState + 1'b1) == matchState)) |=> pendState[FRAME_SRC]); // R9
  AST_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStrobe && !pendState[FRAME_SRC]) |=> !pendState[FRAME_SRC]); // R9
endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
  import audio_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              frameStrobe,
  input  logic [6:0]        eventPulse,
  output logic              irqOut
);
  ctrlStrobe_t        strb;
  logic [NUM_SRC-1:0] enState, pendState;
  logic [CNT_W-1:0]   cntState, matchState;

  audio_irq_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regif_i (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .enState(enState), .pendState(pendState), .cntState(cntState),
    .matchState(matchState), .strb(strb), .regRdData(regRdData)
  );

  audio_irq_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rstN(rstN), .strb(strb), .matchWrData(regWrData[CNT_W-1:0]),
    .frameStrobe(frameStrobe), .eventPulse(eventPulse),
    .enState(enState), .pendState(pendState), .cntState(cntState),
    .matchState(matchState), .irqOut(irqOut)
  );

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (enState == '0) |-> !irqOut); // R6
endmodule

// File: tb/audio_irq_ctrl_tb.sv
module audio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int NSRC = 8;

  logic clk = 0, rstN = 0;
  logic [7:0] regAddr = 0;
  logic regWrEn = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic frameStrobe = 0;
  logic [6:0] eventPulse = 0;
  logic irqOut;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [NSRC-1:0] mEn = 0, mPend = 0;
  logic [CNT_W-1:0] mCnt = 0, mMatch = 0;

  audio_irq_ctrl #(.ADDR_W(8), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .frameStrobe(frameStrobe),
    .eventPulse(eventPulse), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] packCtrl(input logic [NSRC-1:0] en, input logic [NSRC-1:0] pd);
    logic [31:0] w = 0;
    for (int s = 0; s < NSRC; s++) begin
      w[17 + 2*s] = en[s];
      w[16 + 2*s] = pd[s];
    end
    return w;
  endfunction

  function automatic logic [NSRC-1:0] oddBits(input logic [31:0] d);
    logic [NSRC-1:0] v;
    for (int s = 0; s < NSRC; s++) v[s] = d[17 + 2*s];
    return v;
  endfunction

  function automatic logic [NSRC-1:0] evenBits(input logic [31:0] d);
    logic [NSRC-1:0] v;
    for (int s = 0; s < NSRC; s++) v[s] = d[16 + 2*s];
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic fr, input logic [6:0] ev);
    logic [NSRC-1:0] clr;
    logic fire;
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d; frameStrobe = fr; eventPulse = ev;
    @(posedge clk);
    fire = fr && (CNT_W'(mCnt + 1'b1) == mMatch);
    clr = (wr && a == 8'h00) ? evenBits(d) : '0;
    mPend = (mPend & ~clr) | {fire, ev};
    if (wr && a == 8'h00) mEn = oddBits(d);
    if (wr && a == 8'h50) mMatch = d[CNT_W-1:0];
    if (fr) mCnt = CNT_W'(mCnt + 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    regWrEn = 0; frameStrobe = 0; eventPulse = 0; regAddr = a;
    #1 check(tag, regRdData, exp);
  endtask

  task automatic checkAll(input string tag);
    rd(8'h00, {tag, " ctrl R2"}, packCtrl(mEn, mPend));
    check({tag, " irq R6"}, {31'b0, irqOut}, {31'b0, |(mEn & mPend)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 check("R1 irq", {31'b0, irqOut}, 32'd0);
    rstN = 1;
    rd(8'h00, "R1 ctrl", 32'd0);
    rd(8'h40, "R1 count", 32'd0);
    rd(8'h50, "R1 match", 32'd0);

    // R3: pulses set pending with enables off; R6 stays low
    cyc(0, 8'h00, 0, 0, 7'h55);
    checkAll("R3 set w/o enable");
    check("R6 no enable", {31'b0, irqOut}, 32'd0);
    // R5: enable load from odd bits; R2 unused low bits read zero
    cyc(1, 8'h00, 32'hAAAA_FFFF & 32'h2222_FFFF, 0, 0);
    checkAll("R5 enable write");
    check("R2 low bits", {16'b0, regRdData[15:0]}, 32'd0);
    // R4: clear with collision on source 3 (pending bit 22)
    cyc(0, 8'h00, 0, 0, 7'h08);
    cyc(1, 8'h00, 32'h0055_0000, 0, 7'h08);
    checkAll("R4 set wins");
    check("R4 src3 kept", {31'b0, mPend[3]}, 32'd1);
    // R10: unmapped offset ignored and reads zero
    cyc(1, 8'h20, 32'hFFFF_FFFF, 0, 0);
    rd(8'h20, "R10 unmapped read", 32'd0);
    checkAll("R10 no effect");
    // R7: write to count ignored
    cyc(1, 8'h40, 32'h0000_0123, 0, 0);
    rd(8'h40, "R7 count write ignored", 32'(mCnt));
    // R9: match equal to current count raises nothing
    cyc(1, 8'h00, 32'h8000_0000 | 32'h5555_0000, 0, 0);
    cyc(1, 8'h50, 32'(mCnt), 0, 0);
    rd(8'h50, "R8 match readback", 32'(mCnt));
    checkAll("R9 equal write quiet");
    // R9: strobes onto match fire
    cyc(1, 8'h50, 32'(CNT_W'(mCnt + 3)), 0, 0);
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0);
    checkAll("R9 before match");
    cyc(0, 0, 0, 1, 0);
    checkAll("R9 on match");
    check("R9 frame pending", {31'b0, mPend[7]}, 32'd1);
    // R7: wrap
    for (int i = 0; i < (1 << CNT_W); i++) cyc(0, 0, 0, 1, 0);
    rd(8'h40, "R7 after full wrap", 32'(mCnt));
    cyc(1, 8'h00, 32'h5555_0000, 0, 0);
    while (mCnt != '1) cyc(0, 0, 0, 1, 0);
    rd(8'h40, "R7 top value", 32'((1 << CNT_W) - 1));
    cyc(0, 0, 0, 1, 0);
    rd(8'h40, "R7 wrapped to zero", 32'd0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [31:0] d = $urandom;
      logic fr = ($urandom_range(0, 2) == 0);
      logic [6:0] ev = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h0;
      case (sel)
        0, 1: cyc(1, 8'h00, d, fr, ev);
        2: cyc(1, 8'h50, 32'(CNT_W'(mCnt + $urandom_range(0, 3))), fr, ev);
        3: cyc(1, 8'h50, 32'(mCnt), fr, ev);
        4: cyc(1, 8'h40, d, fr, ev);
        default: cyc(0, 8'h00, 0, fr, ev);
      endcase
      if (i % 5 == 0) checkAll("R3 R4 R9 random");
      if (i % 50 == 0) begin
        rd(8'h40, "R7 random count", 32'(mCnt));
        rd(8'h50, "R8 random match", 32'(mMatch));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule